// File: doc/BRIEF.md
# Write-back Cache Tag Controller

This block keeps the tag and state side of a single-level, set-associative, write-back cache. It holds no line data. Each request carries a 32-bit byte address and a 2-bit access type: read, write or invalidate. The block cuts the address into offset, set index and tag, looks up every way of the chosen set in parallel, and then reports one of these results: a hit, a miss with a fill, or a miss that displaces a resident line. A displaced line also reports whether its contents would need writing back.

Set count, way count and line size are compile-time parameters. The victim for a full set comes from a separate least-recently-used tracker. A fill always goes to a free way first, if the set has one. Writes allocate on a miss and leave the line dirty. An invalidate removes a resident line without counting as a hit or a miss, and it raises no eviction or writeback pulse. The block accepts one request per cycle through a valid/ready handshake. Its result appears on registered outputs in the next cycle. A cache model or a performance counter unit can count these outputs.

Top module: `wb_tag_ctrl`

## Requirements
- R1: The byte address is split with the low log2(LINE_BYTES) bits as offset, the next log2(SETS) bits as set index and the remaining upper bits as tag. Two addresses that differ only in the offset fall in the same line.
- R2: `req_type` encodes 0 = read, 1 = write, 2 = invalidate, 3 = reserved.
- R3: `req_ready` is high once reset is released. An accepted request (`req_valid` and `req_ready`) produces `rsp_valid` high in exactly the next cycle, together with its result. Requests are accepted back to back, one per cycle, and each later request sees the state left by the earlier ones.
- R4: For an accepted read or write, exactly one of `rsp_hit` and `rsp_miss` is high. `rsp_way` gives the way that was hit or filled.
- R5: On a miss, the lowest-numbered invalid way in the set is filled, whatever the replacement order is, and no eviction is reported.
- R6: On a miss in a set whose ways are all valid, the least recently used way (by reads and writes, hit or fill) is replaced and `rsp_evict` is high.
- R7: Writes are write-allocate and set the line dirty. `rsp_wb` is high only together with `rsp_evict`, and only when the replaced line is dirty. A line filled by a read starts clean.
- R8: An invalidate to a resident line makes it invalid, and a later access to that line misses. An invalidate never raises `rsp_hit`, `rsp_miss`, `rsp_evict` or `rsp_wb`, even for a dirty line. An invalidate to an absent line changes nothing.
- R9: An accepted request of reserved type 3 raises `rsp_valid` only and leaves all cache state unchanged.
- R10: Reset clears the valid and dirty bits of every way, drives all response outputs low and holds `req_ready` low.
- R11: Sets are independent: activity in one set does not change the contents or the order of another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_type | input | 2 | Access type (R2 encoding) |
| req_addr | input | 32 | Byte address |
| rsp_valid | output | 1 | Result of the request accepted last cycle |
| rsp_hit | output | 1 | Read or write found the line |
| rsp_miss | output | 1 | Read or write did not find the line |
| rsp_evict | output | 1 | A valid line was replaced |
| rsp_wb | output | 1 | The replaced line was dirty |
| rsp_way | output | log2(WAYS) | Way hit, filled or invalidated |

## Verification
The bench fills a set and forces a replacement. Here it checks that a free way always wins over the LRU victim, which a design that asked the policy first would get wrong by evicting a live line. It also checks that a line allocated by a write miss, and a line dirtied by a write hit, both produce a writeback when they are later replaced, while a read-filled line does not. Dirty lines are then invalidated and accessed again. A design that pulsed on invalidate, or left the line valid, would show a false writeback or a false hit. Reserved-type requests, another set, and a mid-run reset each check that stale state does not survive where it must not.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_INVAL = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/wtc_tag_store.sv
// Valid, dirty and tag bits per way per set; one read row, one write port.
module wtc_tag_store #(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [WAYS-1:0]             rd_valid,
  output logic [WAYS-1:0]             rd_dirty,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tags,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic                        wr_valid,
  input  logic                        wr_dirty,
  input  logic                        wr_tag_en,
  input  logic [TAG_W-1:0]            wr_tag
);
  logic [SETS-1:0][WAYS-1:0]            valid_q;
  logic [SETS-1:0][WAYS-1:0]            dirty_q;
  logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tags  = tag_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx][wr_way] <= wr_valid;
      dirty_q[wr_idx][wr_way] <= wr_dirty;
    end
  end

  // Tags need no reset: they are qualified by the valid bits.
  always_ff @(posedge clk) begin
    if (wr_en && wr_tag_en) begin
      tag_q[wr_idx][wr_way] <= wr_tag;
    end
  end
endmodule

// File: rtl/wtc_way_pick.sv
// Parallel tag compare and lowest-free-way search over one set.
module wtc_way_pick #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 22,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             valid,
  input  logic [WAYS-1:0][TAG_W-1:0]  tags,
  input  logic [TAG_W-1:0]            req_tag,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        free,
  output logic [WAY_W-1:0]            free_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = valid[w] && (tags[w] == req_tag);
  end

  always_comb begin
    hit      = |match;
    free     = ~&valid;
    hit_way  = '0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])  hit_way  = WAY_W'(w);
      if (!valid[w]) free_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wtc_lru.sv
// True LRU per set: an age per way, 0 = newest, WAYS-1 = victim.
module wtc_lru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] victim_way,
  input  logic             touch_en,
  input  logic [WAY_W-1:0] touch_way
);
  logic [SETS-1:0][WAYS-1:0][WAY_W-1:0] age_q;
  logic [WAYS-1:0][WAY_W-1:0]           row;
  logic [WAYS-1:0][WAY_W-1:0]           row_nxt;

  assign row = age_q[rd_idx];

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (row[w] == WAY_W'(WAYS - 1)) victim_way = WAY_W'(w);
    end
  end

  always_comb begin
    row_nxt = row;
    for (int w = 0; w < WAYS; w++) begin
      if (WAY_W'(w) == touch_way)        row_nxt[w] = '0;
      else if (row[w] < row[touch_way])  row_nxt[w] = row[w] + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          age_q[s][w] <= WAY_W'(w);
        end
      end
    end else if (touch_en) begin
      age_q[rd_idx] <= row_nxt;
    end
  end
endmodule

// File: rtl/wb_tag_ctrl.sv
module wb_tag_ctrl
  import wtc_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_type,
  input  logic [31:0]      req_addr,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic             rsp_evict,
  output logic             rsp_wb,
  output logic [WAY_W-1:0] rsp_way
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = 32 - OFF_W - IDX_W;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       irst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign irst_n    = rst_sync_q[1];
  assign req_ready = irst_n;

  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             is_rd, is_wr, is_inv;
  assign accept = req_valid && req_ready;
  assign idx    = req_addr[OFF_W +: IDX_W];
  assign tag    = req_addr[31 -: TAG_W];
  assign is_rd  = (acc_e'(req_type) == ACC_READ);
  assign is_wr  = (acc_e'(req_type) == ACC_WRITE);
  assign is_inv = (acc_e'(req_type) == ACC_INVAL);

  logic [WAYS-1:0]            set_valid, set_dirty;
  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  logic                       hit, free;
  logic [WAY_W-1:0]           hit_way, free_way, victim_way;

  // Next-state of the addressed way
  logic             wr_en, wr_valid, wr_dirty, wr_tag_en, touch_en;
  logic [WAY_W-1:0] sel_way;
  logic             evict_nxt, wb_nxt;

  always_comb begin
    sel_way   = hit ? hit_way : (free ? free_way : victim_way);
    wr_en     = 1'b0;
    wr_valid  = 1'b0;
    wr_dirty  = 1'b0;
    wr_tag_en = 1'b0;
    touch_en  = 1'b0;
    evict_nxt = 1'b0;
    wb_nxt    = 1'b0;
    if (accept && (is_rd || is_wr)) begin
      wr_en     = 1'b1;
      wr_valid  = 1'b1;
      wr_tag_en = !hit;
      wr_dirty  = is_wr || (hit && set_dirty[hit_way]);
      touch_en  = 1'b1;
      evict_nxt = !hit && !free;
      wb_nxt    = !hit && !free && set_dirty[victim_way];
    end else if (accept && is_inv && hit) begin
      wr_en = 1'b1;
    end
  end

  wtc_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) i_store (
    .clk       (clk),
    .rst_n     (irst_n),
    .rd_idx    (idx),
    .rd_valid  (set_valid),
    .rd_dirty  (set_dirty),
    .rd_tags   (set_tags),
    .wr_en     (wr_en),
    .wr_idx    (idx),
    .wr_way    (sel_way),
    .wr_valid  (wr_valid),
    .wr_dirty  (wr_dirty),
    .wr_tag_en (wr_tag_en),
    .wr_tag    (tag)
  );

  wtc_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W)) i_pick (
    .valid    (set_valid),
    .tags     (set_tags),
    .req_tag  (tag),
    .hit      (hit),
    .hit_way  (hit_way),
    .free     (free),
    .free_way (free_way)
  );

  wtc_lru #(.SETS(SETS), .WAYS(WAYS)) i_lru (
    .clk        (clk),
    .rst_n      (irst_n),
    .rd_idx     (idx),
    .victim_way (victim_way),
    .touch_en   (touch_en),
    .touch_way  (sel_way)
  );

  // Response registers
  logic             rv_d, rh_d, rm_d;
  logic [WAY_W-1:0] rw_d;
  always_comb begin
    rv_d = accept;
    rh_d = accept && (is_rd || is_wr) && hit;
    rm_d = accept && (is_rd || is_wr) && !hit;
    rw_d = (accept && !(acc_e'(req_type) == ACC_RSVD)) ? sel_way : '0;
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_evict <= 1'b0;
      rsp_wb    <= 1'b0;
      rsp_way   <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_hit   <= rh_d;
      rsp_miss  <= rm_d;
      rsp_evict <= evict_nxt;
      rsp_wb    <= wb_nxt;
      rsp_way   <= rw_d;
    end
  end
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_type,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_evict,
  input logic             rsp_wb,
  input logic [WAY_W-1:0] rsp_way
);
  // R3
  rsp_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  // R3
  no_rsp_without_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R4
  hit_miss_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));

  // R6
  evict_needs_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_evict |-> rsp_miss);

  // R7
  wb_needs_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_wb |-> rsp_evict);

  // R8
  inval_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'd2) |=>
      (!rsp_hit && !rsp_miss && !rsp_evict && !rsp_wb));

  // R9
  rsvd_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'd3) |=>
      (!rsp_hit && !rsp_miss && !rsp_evict && !rsp_wb));

  // R10
  idle_outputs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && !rsp_miss && !rsp_evict && !rsp_wb && rsp_way == '0));
endmodule

bind wb_tag_ctrl wtc_chk #(.WAYS(WAYS)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_type  (req_type),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_miss  (rsp_miss),
  .rsp_evict (rsp_evict),
  .rsp_wb    (rsp_wb),
  .rsp_way   (rsp_way)
);

// File: tb/test_wb_tag_ctrl.sv
`timescale 1ns/1ps
module test_wb_tag_ctrl;
  // Defaults: 16 sets, 4 ways, 64-byte lines -> offset [5:0], index [9:6], tag [31:10]
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [1:0]  req_type;
  logic [31:0] req_addr;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_evict, rsp_wb;
  logic [1:0] rsp_way;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  wb_tag_ctrl i_wb_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_type(req_type), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_evict(rsp_evict),
    .rsp_wb(rsp_wb), .rsp_way(rsp_way)
  );

  // Row: op[26:25] tag[24:17] idx[16:13] off[12:7] chkway[6] hit[5] miss[4] evict[3] wb[2] way[1:0]
  localparam int NV = 23;
  localparam logic [26:0] VEC [0:NV-1] = '{
    {2'd0, 8'd1,  4'd1, 6'd0, 7'b1_0100_00},  // fill free way0
    {2'd0, 8'd1,  4'd1, 6'd4, 7'b1_1000_00},  // R1 same line, other offset
    {2'd1, 8'd2,  4'd1, 6'd8, 7'b1_0100_01},  // write miss allocates way1
    {2'd0, 8'd3,  4'd1, 6'd0, 7'b1_0100_10},
    {2'd0, 8'd4,  4'd1, 6'd0, 7'b1_0100_11},
    {2'd1, 8'd1,  4'd1, 6'd0, 7'b1_1000_00},  // write hit
    {2'd0, 8'd5,  4'd1, 6'd0, 7'b1_0111_01},  // victim way1 dirty -> wb
    {2'd0, 8'd6,  4'd1, 6'd0, 7'b1_0110_10},  // victim way2 clean
    {2'd2, 8'd1,  4'd1, 6'd0, 7'b0_0000_00},  // invalidate dirty way0
    {2'd0, 8'd7,  4'd1, 6'd0, 7'b1_0100_00},  // free way beats LRU
    {2'd2, 8'd8,  4'd1, 6'd0, 7'b0_0000_00},  // invalidate absent
    {2'd0, 8'd1,  4'd1, 6'd0, 7'b1_0110_11},  // re-miss after invalidate
    {2'd1, 8'd4,  4'd1, 6'd0, 7'b1_0110_01},
    {2'd0, 8'd1,  4'd2, 6'd0, 7'b1_0100_00},  // other set independent
    {2'd2, 8'd4,  4'd1, 6'd0, 7'b0_0000_00},  // invalidate dirty way1
    {2'd0, 8'd4,  4'd1, 6'd0, 7'b1_0100_01},
    {2'd3, 8'd7,  4'd1, 6'd0, 7'b0_0000_00},  // reserved type
    {2'd0, 8'd7,  4'd1, 6'd0, 7'b1_1000_00},
    {2'd1, 8'd6,  4'd1, 6'd0, 7'b1_1000_10},  // dirty via write hit
    {2'd0, 8'd9,  4'd1, 6'd0, 7'b1_0110_11},
    {2'd0, 8'd10, 4'd1, 6'd0, 7'b1_0110_01},
    {2'd0, 8'd11, 4'd1, 6'd0, 7'b1_0110_00},
    {2'd0, 8'd12, 4'd1, 6'd0, 7'b1_0111_10}   // dirty victim way2 -> wb
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [26:0] v);
    req_valid = 1'b1;
    req_type  = v[26:25];
    req_addr  = {14'd0, v[24:17], v[16:13], v[12:7]};
  endtask

  function automatic string tag_of(input logic [26:0] v);
    if (v[26:25] == 2'd2) return "R8";
    if (v[26:25] == 2'd3) return "R9";
    if (v[2])  return "R7";
    if (v[3])  return "R6";
    if (v[16:13] != 4'd1) return "R11";
    if (v[4])  return "R5";
    return "R4";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_type = 2'd0; req_addr = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", {2'd0, rsp_way, rsp_valid, rsp_hit, rsp_miss, rsp_evict, req_ready}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R3", {7'd0, req_ready}, 8'd1);

    // Table walk: one request per cycle, response checked one cycle later
    drive(VEC[0]);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      begin
        logic [7:0] act, exp;
        act = {3'd0, rsp_hit, rsp_miss, rsp_evict, rsp_wb, 1'b0};
        exp = {3'd0, VEC[i][5:2], 1'b0};
        check(tag_of(VEC[i]), act, exp);
        check("R3", {7'd0, rsp_valid}, 8'd1);
        if (VEC[i][6]) check(tag_of(VEC[i]), {6'd0, rsp_way}, {6'd0, VEC[i][1:0]});
      end
      if (i + 1 < NV) drive(VEC[i + 1]);
      else req_valid = 1'b0;
    end

    // R3 idle cycle: no response
    @(negedge clk);
    check("R3", {4'd0, rsp_valid, rsp_hit, rsp_miss, rsp_evict}, 8'd0);

    // R10 mid-run reset clears residency
    rst_n = 1'b0;
    #1;
    check("R10", {4'd0, rsp_valid, rsp_hit, rsp_miss, req_ready}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive({2'd0, 8'd7, 4'd1, 6'd0, 7'd0});   // resident before reset
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", {3'd0, rsp_hit, rsp_miss, rsp_evict, rsp_way}, {3'd0, 1'b0, 1'b1, 1'b0, 2'd0});

    // R2/R4 write then read of same line after reset
    drive({2'd1, 8'd7, 4'd1, 6'd3, 7'd0});
    @(negedge clk);
    req_valid = 1'b0;
    check("R2", {6'd0, rsp_hit, rsp_miss}, 8'b10);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule